// File: doc/BRIEF.md
# Programmable Pixel and Memory Clock Divider

This block produces two divided clocks for a display controller: a pixel clock derived from the incoming video clock, and a memory clock derived from either the video clock or an independent system clock. Each output has its own 2-bit ratio code. The available ratios are pass-through, divide-by-1.5, divide-by-2 and divide-by-4. The divide-by-1.5 output is built from logic on both edges of its source clock, so its edges land on input half-period boundaries.

The mapping from code to ratio for the pixel clock is fixed at build time by a parameter. It selects one of two chip-variant tables. The memory clock always uses the same table. The memory clock source is chosen by a select bit. That bit only counts while a separate enable bit is set; otherwise the system clock is used.

A ratio change is never applied in the middle of an output period. The divider finishes its current period, or its current group of periods, at the old ratio and then switches, so no shortened pulse appears. Reset is synchronous and active low. While reset is held, both outputs pass their source clock straight through and all counters are cleared.

Top module: `vclk_mclk_div`

## Requirements
- R1: While `rst_n` is low, `pix_clk_out` follows `vid_clk` and `mem_clk_out` follows its selected source clock, each with period and high time equal to the input's.
- R2: After `rst_n` is released, the first rising edge of a divided output comes at the next rising edge of its source clock. The first period then has the full high time of the requested ratio.
- R3: With `VARIANT` = 0, `pix_div_code` selects the pixel ratio as follows: 0 = pass-through, 1 = divide by 1.5, 2 = divide by 2, 3 = divide by 4.
- R4: With `VARIANT` = 1, `pix_div_code` selects the pixel ratio as follows: 0 = pass-through, 1 = divide by 2, 2 = divide by 4, 3 = divide by 4.
- R5: For either `VARIANT`, `mem_div_code` selects the memory ratio as follows: 0 = pass-through, 1 = divide by 1.5, 2 = divide by 2, 3 = divide by 4.
- R6: An integer ratio N gives an output period of 2N input half-periods, high for N and low for N.
- R7: Divide by 1.5 gives an output period of 3 input half-periods: high for 2, then low for 1.
- R8: With `mem_src_en` = 1 and `mem_src_vid` = 1, the memory divider runs from `vid_clk`.
- R9: With `mem_src_en` = 0, the memory divider runs from `sys_clk` whatever the value of `mem_src_vid`.
- R10: With `mem_src_en` = 1 and `mem_src_vid` = 0, the memory divider runs from `sys_clk`.
- R11: A new code is applied only when the current output period has finished (for divide by 1.5, at the end of a pair of periods). The period in progress keeps its old high and low times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vid_clk | input | 1 | Video clock; source of the pixel divider and optional source of the memory divider |
| sys_clk | input | 1 | System clock; default source of the memory divider |
| rst_n | input | 1 | Synchronous active-low reset, sampled by each divider on its own source clock |
| pix_div_code | input | 2 | Pixel clock ratio code, mapped by the `VARIANT` table |
| mem_div_code | input | 2 | Memory clock ratio code |
| mem_src_vid | input | 1 | Memory source select: 1 picks the video clock |
| mem_src_en | input | 1 | Qualifies `mem_src_vid`; when 0 the system clock is used |
| pix_clk_out | output | 1 | Divided pixel clock |
| mem_clk_out | output | 1 | Divided memory clock |

## Verification
On every rising source edge, the assertions check three things: the phase counter stays inside the span of the active ratio, the active ratio holds steady everywhere except at a group boundary, and the falling-phase register is only set in the middle cycle of a divide-by-1.5 group. These checks cover the no-runt switching rule and the shape of the 1.5 waveform in the divider's internal state. The bench checks behaviour in absolute time. It measures period and high time against the input half-periods for every code in both variant tables and for every source-select combination, times the first period after reset release, and changes the code partway through a period to show that the period in progress ends at its old length.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Width of the per-group phase counter (largest group is four cycles)
    localparam int DIV_CNT_W = 2;

    typedef enum logic [1:0] {
        DIV_PASS = 2'd0,
        DIV_1P5  = 2'd1,
        DIV_2    = 2'd2,
        DIV_4    = 2'd3
    } ratio_e;

    typedef struct packed {
        ratio_e                 mode;  // ratio applied in the current group
        logic [DIV_CNT_W-1:0]   cnt;   // source-cycle index inside the group
        logic                   rise;  // output level set on the rising edge
    } div_state_t;

    // Index of the last source cycle of one output group
    function automatic logic [DIV_CNT_W-1:0] last_cnt(ratio_e r);
        case (r)
            DIV_1P5: last_cnt = DIV_CNT_W'(2);
            DIV_2:   last_cnt = DIV_CNT_W'(1);
            DIV_4:   last_cnt = DIV_CNT_W'(3);
            default: last_cnt = '0;
        endcase
    endfunction

    // Level driven from the rising-edge register for a given group cycle
    function automatic logic hi_phase(ratio_e r, logic [DIV_CNT_W-1:0] c);
        case (r)
            DIV_1P5: hi_phase = (c == '0);
            DIV_2:   hi_phase = (c == '0);
            DIV_4:   hi_phase = (c < DIV_CNT_W'(2));
            default: hi_phase = 1'b0;
        endcase
    endfunction

    // Level driven from the falling-edge register; only the 1.5 ratio uses it
    function automatic logic lo_phase(ratio_e r, logic [DIV_CNT_W-1:0] c);
        lo_phase = (r == DIV_1P5) && (c == DIV_CNT_W'(1));
    endfunction

endpackage

// File: rtl/clkdiv_ratio_map.sv
module clkdiv_ratio_map
    import clkdiv_pkg::*;
#(
    parameter int TABLE = 0   // 0: table with 1.5 step, 1: integer-only table
) (
    input  logic [1:0] code,
    output ratio_e     ratio
);

    generate
        if (TABLE == 1) begin : g_int_table
            always_comb begin
                case (code)
                    2'd0:    ratio = DIV_PASS;
                    2'd1:    ratio = DIV_2;
                    default: ratio = DIV_4;
                endcase
            end
        end else begin : g_frac_table
            always_comb begin
                case (code)
                    2'd0:    ratio = DIV_PASS;
                    2'd1:    ratio = DIV_1P5;
                    2'd2:    ratio = DIV_2;
                    default: ratio = DIV_4;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux (
    input  logic clk_vid,
    input  logic clk_sys,
    input  logic pick_vid,
    input  logic pick_en,
    output logic clk_o
);

    // Select is treated as static configuration; the video clock is taken
    // only when the qualifying enable is also set.
    logic use_vid;
    assign use_vid = pick_en & pick_vid;
    assign clk_o   = use_vid ? clk_vid : clk_sys;

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = DIV_CNT_W
) (
    input  logic   clk_in,
    input  logic   rst_n,
    input  ratio_e req,
    output logic   clk_out
);

    div_state_t st_q, st_d;
    logic       fall_q;
    logic       at_last;

    assign at_last = (st_q.cnt == last_cnt(st_q.mode));

    // Next group state: a new ratio is accepted only on the last cycle
    always_comb begin
        st_d = st_q;
        if (at_last) begin
            st_d.mode = req;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
        end
        st_d.rise = hi_phase(st_d.mode, st_d.cnt);
    end

    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            st_q <= '{mode: DIV_PASS, cnt: '0, rise: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // Falling-edge half: fills in the mid-cycle rise of the 1.5 waveform
    always_ff @(negedge clk_in) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= lo_phase(st_q.mode, st_q.cnt);
        end
    end

    assign clk_out = (st_q.mode == DIV_PASS) ? clk_in : (st_q.rise | fall_q);

    // R11: the ratio only moves at a group boundary
    ratio_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        !at_last |=> $stable(st_q.mode));

    // R6
    cnt_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        st_q.cnt <= last_cnt(st_q.mode));

    // R7: mid-cycle rise exists only in the middle cycle of a 1.5 group
    fall_phase_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        fall_q |-> (st_q.mode == DIV_1P5 && st_q.cnt == CNT_W'(1)));

    // R7: both halves never drive high together
    half_excl_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        !(st_q.rise && fall_q));

endmodule

// File: rtl/vclk_mclk_div.sv
module vclk_mclk_div
    import clkdiv_pkg::*;
#(
    parameter int VARIANT = 0   // pixel ratio table: 0 with 1.5 step, 1 integer-only
) (
    input  logic       vid_clk,
    input  logic       sys_clk,
    input  logic       rst_n,
    input  logic [1:0] pix_div_code,
    input  logic [1:0] mem_div_code,
    input  logic       mem_src_vid,
    input  logic       mem_src_en,
    output logic       pix_clk_out,
    output logic       mem_clk_out
);

    ratio_e pix_ratio;
    ratio_e mem_ratio;
    logic   mem_src_clk;

    clkdiv_ratio_map #(.TABLE(VARIANT)) u_pix_map (
        .code  (pix_div_code),
        .ratio (pix_ratio)
    );

    clkdiv_ratio_map #(.TABLE(0)) u_mem_map (
        .code  (mem_div_code),
        .ratio (mem_ratio)
    );

    clkdiv_src_mux u_mem_src (
        .clk_vid  (vid_clk),
        .clk_sys  (sys_clk),
        .pick_vid (mem_src_vid),
        .pick_en  (mem_src_en),
        .clk_o    (mem_src_clk)
    );

    clkdiv_core u_pix_div (
        .clk_in  (vid_clk),
        .rst_n   (rst_n),
        .req     (pix_ratio),
        .clk_out (pix_clk_out)
    );

    clkdiv_core u_mem_div (
        .clk_in  (mem_src_clk),
        .rst_n   (rst_n),
        .req     (mem_ratio),
        .clk_out (mem_clk_out)
    );

endmodule

// File: tb/sim_vclk_mclk_div.sv
`timescale 1ns/1ps
module sim_vclk_mclk_div;

    localparam int CLK_PERIOD = 10;
    localparam int SYS_PERIOD = 14;
    localparam int VH = CLK_PERIOD / 2;
    localparam int SH = SYS_PERIOD / 2;

    logic       vclk = 1'b0;
    logic       sclk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pix_code = 2'd0;
    logic [1:0] mem_code = 2'd0;
    logic       src_vid = 1'b0;
    logic       src_en = 1'b0;
    logic       pix0, mem0, pix1, mem1;
    int         mon_sel = 0;
    logic       mon;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #(VH) vclk = ~vclk;
    always #(SH) sclk = ~sclk;

    vclk_mclk_div #(.VARIANT(0)) u0 (
        .vid_clk(vclk), .sys_clk(sclk), .rst_n(rst_n),
        .pix_div_code(pix_code), .mem_div_code(mem_code),
        .mem_src_vid(src_vid), .mem_src_en(src_en),
        .pix_clk_out(pix0), .mem_clk_out(mem0)
    );

    vclk_mclk_div #(.VARIANT(1)) u1 (
        .vid_clk(vclk), .sys_clk(sclk), .rst_n(rst_n),
        .pix_div_code(pix_code), .mem_div_code(mem_code),
        .mem_src_vid(src_vid), .mem_src_en(src_en),
        .pix_clk_out(pix1), .mem_clk_out(mem1)
    );

    always_comb begin
        if (mon_sel == 0)      mon = pix0;
        else if (mon_sel == 1) mon = mem0;
        else if (mon_sel == 2) mon = pix1;
        else                   mon = mem1;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Twice the divide factor per code, taken from the requirement tables
    function automatic int div2x(input bit int_table, input logic [1:0] code);
        if (int_table) begin
            case (code)
                2'd0: div2x = 2;
                2'd1: div2x = 4;
                default: div2x = 8;
            endcase
        end else begin
            case (code)
                2'd0: div2x = 2;
                2'd1: div2x = 3;
                2'd2: div2x = 4;
                default: div2x = 8;
            endcase
        end
    endfunction

    // High half-periods: 1.5 ratio is high for 2 of 3, integer ratios for half
    function automatic int hi_halves(input int d2x);
        hi_halves = (d2x == 3) ? 2 : d2x / 2;
    endfunction

    task automatic measure(input int sel, output longint per, output longint hi);
        longint t0, t1, t2;
        mon_sel = sel;
        #1;
        repeat (3) @(posedge mon);
        t0 = $time;
        @(negedge mon);
        t1 = $time;
        @(posedge mon);
        t2 = $time;
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    task automatic t_reset();
        longint per, hi;
        rst_n = 1'b0; pix_code = 2'd3; mem_code = 2'd3; src_en = 1'b0; src_vid = 1'b1;
        repeat (10) @(posedge vclk);
        measure(0, per, hi);
        check("R1", "pix period in reset", per, CLK_PERIOD);
        check("R1", "pix high in reset", hi, VH);
        measure(2, per, hi);
        check("R1", "variant-1 pix period in reset", per, CLK_PERIOD);
        measure(1, per, hi);
        check("R1", "mem period in reset", per, SYS_PERIOD);
        check("R1", "mem high in reset", hi, SH);
    endtask

    task automatic t_release();
        longint trel, t0, t1;
        mon_sel = 0;
        @(posedge vclk);
        #2;
        @(negedge vclk);
        rst_n = 1'b1;
        trel = $time;
        @(posedge mon);
        t0 = $time;
        @(negedge mon);
        t1 = $time;
        check("R2", "first rise after release", t0 - trel, VH);
        check("R2", "first high time at divide by 4", t1 - t0, 4 * VH);
    endtask

    task automatic t_pix_tables();
        longint per, hi;
        for (int c = 0; c < 4; c++) begin
            pix_code = 2'(c);
            repeat (12) @(posedge vclk);
            measure(0, per, hi);
            check((c == 1) ? "R3 R7" : "R3 R6", $sformatf("variant 0 code %0d period", c),
                  per, div2x(1'b0, 2'(c)) * VH);
            check((c == 1) ? "R3 R7" : "R3 R6", $sformatf("variant 0 code %0d high", c),
                  hi, hi_halves(div2x(1'b0, 2'(c))) * VH);
            measure(2, per, hi);
            check("R4 R6", $sformatf("variant 1 code %0d period", c),
                  per, div2x(1'b1, 2'(c)) * VH);
            check("R4 R6", $sformatf("variant 1 code %0d high", c),
                  hi, hi_halves(div2x(1'b1, 2'(c))) * VH);
        end
    endtask

    task automatic t_mem_table();
        longint per, hi;
        src_en = 1'b0; src_vid = 1'b0;
        for (int c = 0; c < 4; c++) begin
            mem_code = 2'(c);
            repeat (12) @(posedge sclk);
            measure(1, per, hi);
            check((c == 1) ? "R5 R7" : "R5 R6", $sformatf("mem code %0d period", c),
                  per, div2x(1'b0, 2'(c)) * SH);
            check((c == 1) ? "R5 R7" : "R5 R6", $sformatf("mem code %0d high", c),
                  hi, hi_halves(div2x(1'b0, 2'(c))) * SH);
            measure(3, per, hi);
            check("R5", $sformatf("variant-1 mem code %0d period", c),
                  per, div2x(1'b0, 2'(c)) * SH);
            check("R5", $sformatf("variant-1 mem code %0d high", c),
                  hi, hi_halves(div2x(1'b0, 2'(c))) * SH);
        end
    endtask

    task automatic t_src();
        longint per, hi;
        mem_code = 2'd2;
        src_en = 1'b1; src_vid = 1'b1;
        repeat (12) @(posedge sclk);
        measure(1, per, hi);
        check("R8", "mem period from video clock", per, 4 * VH);
        check("R8", "mem high from video clock", hi, 2 * VH);
        src_en = 1'b0; src_vid = 1'b1;
        repeat (12) @(posedge sclk);
        measure(1, per, hi);
        check("R9", "mem period with enable clear, select set", per, 4 * SH);
        check("R9", "mem high with enable clear, select set", hi, 2 * SH);
        src_en = 1'b1; src_vid = 1'b0;
        repeat (12) @(posedge sclk);
        measure(1, per, hi);
        check("R10", "mem period with enable set, select clear", per, 4 * SH);
        check("R10", "mem high with enable set, select clear", hi, 2 * SH);
    endtask

    task automatic t_switch();
        longint t0, t1, t2, t3, t4;
        pix_code = 2'd3;
        repeat (16) @(posedge vclk);
        mon_sel = 0;
        #1;
        @(posedge mon);
        t0 = $time;
        #1;
        pix_code = 2'd2;
        @(negedge mon); t1 = $time;
        @(posedge mon); t2 = $time;
        @(negedge mon); t3 = $time;
        check("R11", "high of period in progress (divide by 4)", t1 - t0, 4 * VH);
        check("R11", "low of period in progress (divide by 4)", t2 - t1, 4 * VH);
        check("R11", "first high after switch to divide by 2", t3 - t2, 2 * VH);
        @(posedge mon); t0 = $time;
        #1;
        pix_code = 2'd1;
        @(negedge mon); t1 = $time;
        @(posedge mon); t2 = $time;
        @(negedge mon); t3 = $time;
        @(posedge mon); t4 = $time;
        check("R11", "low of period in progress (divide by 2)", t2 - t1, 2 * VH);
        check("R11 R7", "first high after switch to divide by 1.5", t3 - t2, 2 * VH);
        check("R11 R7", "first low after switch to divide by 1.5", t4 - t3, VH);
    endtask

    initial begin
        t_reset();
        t_release();
        t_pix_tables();
        t_mem_table();
        t_src();
        t_switch();
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule